// File: doc/BRIEF.md
# Dual-Section Decade Counter with Preset to Nine

This block is a four-bit decade counter built from two stages that each have their own count strobe: a one-bit stage that toggles (the half stage) and a three-bit stage that counts modulo five (the fifth stage). The whole block runs on one system clock. Both strobes pass through a two-flop synchronizer, and a stage acts on the strobe's high-to-low transition. A two-bit link input picks how the stages are chained inside the block. In BCD mode the count runs 0 to 9 in 8421 code. In bi-quinary mode it divides by ten and bit 0 becomes a symmetric square wave. In independent mode the two stages are separate dividers.

Two gated control pairs act on the count. When both inputs of the clear pair are high, the count is forced to zero. When both inputs of the preset pair are high, the count is forced to nine, and this wins over the clear. Both controls take effect on the system clock edge. A synchronous active-high reset clears the count and the edge history.

Top module: `decade_dual_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count_o` becomes 0 and no strobe edge is pending afterwards.
- R2: When `clr_a_i` and `clr_b_i` are both high (and the preset pair is not), `count_o` is 0 after the next clock edge, and strobe edges do not change it.
- R3: When `nine_a_i` and `nine_b_i` are both high, `count_o` is 9 (bit 0 = 1, bit 3 = 1, bits 2..1 = 0) after the next clock edge, whatever the clear pair and the strobes do.
- R4: Counting continues normally whenever at least one input of each control pair is low.
- R5: With `mode_i` = 00 (BCD), each falling edge of `tick_a_i` adds one to `count_o`, and the count wraps from 9 to 0. The half stage's 1-to-0 transition steps the fifth stage in the same cycle.
- R6: With `mode_i` = 01 (bi-quinary), each falling edge of `tick_b_i` steps the fifth stage (bits 3..1 run 0,1,2,3,4,0). The fifth stage's 4-to-0 wrap toggles bit 0 in the same cycle, so bit 0 is high for five input counts and then low for five.
- R7: With `mode_i` = 10 (independent), a `tick_a_i` fall toggles only bit 0, and a `tick_b_i` fall steps only bits 3..1 modulo five.
- R8: The count changes on the third rising clock edge after a strobe is driven low, and not before. Rising strobe edges and steady levels change nothing.
- R9: In a linked mode the strobe of the stage driven from inside the block is ignored: `tick_b_i` in BCD mode and `tick_a_i` in bi-quinary mode.
- R10: Writing `mode_i` does not change the present count. The code 11 behaves as independent mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Stage linking: 00 BCD, 01 bi-quinary, 10/11 independent |
| tick_a_i | input | 1 | Count strobe of the half stage, acts on its falling edge |
| tick_b_i | input | 1 | Count strobe of the fifth stage, acts on its falling edge |
| clr_a_i | input | 1 | Clear pair input A |
| clr_b_i | input | 1 | Clear pair input B |
| nine_a_i | input | 1 | Preset-to-nine pair input A |
| nine_b_i | input | 1 | Preset-to-nine pair input B |
| count_o | output | 4 | Count, bit i is output Qi |

## Verification
Every strobe edge reaches `count_o` on a fixed clock edge, so a wrong state in the half or fifth stage shows at the port three edges after the strobe that caused it. A missing or extra cascade step shows at the next wrap, no more than ten strobes later. The sweeps therefore compare the port after every single strobe with a model of two small integers. A stuck edge detector shows either as a count that never moves or as a count that moves on the wrong edge.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef enum logic [1:0] {
        LINK_BCD   = 2'b00,
        LINK_BIQ   = 2'b01,
        LINK_INDEP = 2'b10,
        LINK_SPARE = 2'b11
    } link_e;

    typedef enum logic [1:0] {
        CTL_COUNT  = 2'b00,
        CTL_CLEAR  = 2'b01,
        CTL_PRESET = 2'b10
    } ctl_e;

    localparam int          QUIN_W    = 3;
    localparam int          COUNT_W   = QUIN_W + 1;
    localparam logic [2:0]  QUIN_LAST = 3'd4;
    localparam logic [3:0]  COUNT_NINE = 4'd9;

    typedef struct packed {
        logic [QUIN_W-1:0] quin;
        logic              half;
    } count_t;

    // Modulo-five successor; unused codes return to zero.
    function automatic logic [QUIN_W-1:0] quin_next(input logic [QUIN_W-1:0] q);
        return (q >= QUIN_LAST) ? '0 : q + 1'b1;
    endfunction

    // Preset beats clear beats counting.
    function automatic ctl_e ctl_decode(input logic c_a, input logic c_b,
                                        input logic p_a, input logic p_b);
        if (p_a && p_b)      return CTL_PRESET;
        else if (c_a && c_b) return CTL_CLEAR;
        else                 return CTL_COUNT;
    endfunction

endpackage

// File: rtl/dc_fall_detect.sv
module dc_fall_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic fall_o
);
    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= strobe_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[SYNC_STAGES-1];
    end

    assign fall_o = prev_q && !chain_q[SYNC_STAGES-1];

    // A detected fall cannot repeat in the next cycle.
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dc_half_stage.sv
module dc_half_stage
    import dc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_e ctl_i,
    input  logic step_i,
    output logic half_o
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= 1'b0;
        end else begin
            unique case (ctl_i)
                CTL_PRESET: half_q <= 1'b1;
                CTL_CLEAR:  half_q <= 1'b0;
                default:    if (step_i) half_q <= !half_q;
            endcase
        end
    end

    assign half_o = half_q;

    // R7: with counting enabled, a step always flips the bit.
    assert_half_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_i == CTL_COUNT && step_i) |=> (half_o != $past(half_o)));

endmodule

// File: rtl/dc_fifth_stage.sv
module dc_fifth_stage
    import dc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctl_e              ctl_i,
    input  logic              step_i,
    output logic [QUIN_W-1:0] quin_o
);
    logic [QUIN_W-1:0] quin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quin_q <= '0;
        end else begin
            unique case (ctl_i)
                CTL_PRESET: quin_q <= QUIN_LAST;
                CTL_CLEAR:  quin_q <= '0;
                default:    if (step_i) quin_q <= quin_next(quin_q);
            endcase
        end
    end

    assign quin_o = quin_q;

    // R6: the stage stays inside its five codes.
    assert_quin_range_R6: assert property (@(posedge clk) disable iff (rst)
        quin_o <= QUIN_LAST);

    // R6: the last code always returns to zero on a step.
    assert_quin_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_i == CTL_COUNT && step_i && quin_o == QUIN_LAST) |=> (quin_o == '0));

endmodule

// File: rtl/decade_dual_counter.sv
module decade_dual_counter
    import dc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_i,
    input  logic       tick_a_i,
    input  logic       tick_b_i,
    input  logic       clr_a_i,
    input  logic       clr_b_i,
    input  logic       nine_a_i,
    input  logic       nine_b_i,
    output logic [3:0] count_o
);
    link_e             link;
    ctl_e              ctl;
    logic              fall_a, fall_b;
    logic              half_q;
    logic [QUIN_W-1:0] quin_q;
    logic              bcd_carry, biq_carry;
    logic              half_step, fifth_step;
    count_t            cnt;

    assign link = link_e'(mode_i);
    assign ctl  = ctl_decode(clr_a_i, clr_b_i, nine_a_i, nine_b_i);

    dc_fall_detect #(.SYNC_STAGES(2)) u_fall_a (
        .clk(clk), .rst(rst), .strobe_i(tick_a_i), .fall_o(fall_a)
    );

    dc_fall_detect #(.SYNC_STAGES(2)) u_fall_b (
        .clk(clk), .rst(rst), .strobe_i(tick_b_i), .fall_o(fall_b)
    );

    // Internal cascade edges, seen in the same cycle as their cause.
    assign bcd_carry = fall_a && half_q;
    assign biq_carry = fall_b && (quin_q == QUIN_LAST);

    always_comb begin
        unique case (link)
            LINK_BCD: begin
                half_step  = fall_a;
                fifth_step = bcd_carry;
            end
            LINK_BIQ: begin
                half_step  = biq_carry;
                fifth_step = fall_b;
            end
            default: begin
                half_step  = fall_a;
                fifth_step = fall_b;
            end
        endcase
    end

    dc_half_stage u_half (
        .clk(clk), .rst(rst), .ctl_i(ctl), .step_i(half_step), .half_o(half_q)
    );

    dc_fifth_stage u_fifth (
        .clk(clk), .rst(rst), .ctl_i(ctl), .step_i(fifth_step), .quin_o(quin_q)
    );

    assign cnt.half = half_q;
    assign cnt.quin = quin_q;
    assign count_o  = cnt;

    // R3: both preset inputs high force nine at the next edge.
    assert_preset_nine_R3: assert property (@(posedge clk) disable iff (rst)
        (nine_a_i && nine_b_i) |=> (count_o == COUNT_NINE));

    // R2: clear without preset forces zero at the next edge.
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_a_i && clr_b_i && !(nine_a_i && nine_b_i)) |=> (count_o == 4'd0));

    // R5: the count never leaves 0..9.
    assert_count_le9_R5: assert property (@(posedge clk) disable iff (rst)
        count_o <= COUNT_NINE);

    // R10: without a strobe edge or a control, the count holds.
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!fall_a && !fall_b && ctl == CTL_COUNT) |=> $stable(count_o));

    // R1: the cycle after reset the count is zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count_o == 4'd0));

endmodule

// File: tb/decade_dual_counter_bench.sv
module decade_dual_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_i = 2'b00;
    logic       tick_a_i = 1'b0, tick_b_i = 1'b0;
    logic       clr_a_i = 1'b0, clr_b_i = 1'b0;
    logic       nine_a_i = 1'b0, nine_b_i = 1'b0;
    logic [3:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model: bit 0 and the modulo-five stage.
    int eq0 = 0;
    int equ = 0;

    always #5 clk = ~clk;

    decade_dual_counter u_decade_dual_counter (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .tick_a_i(tick_a_i), .tick_b_i(tick_b_i),
        .clr_a_i(clr_a_i), .clr_b_i(clr_b_i),
        .nine_a_i(nine_a_i), .nine_b_i(nine_b_i),
        .count_o(count_o)
    );

    function automatic int exp_val();
        return eq0 + 2 * equ;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_a();
        if (mode_i == 2'b00) begin
            if (eq0 == 1) equ = (equ + 1) % 5;
            eq0 = 1 - eq0;
        end else if (mode_i != 2'b01) begin
            eq0 = 1 - eq0;
        end
    endtask

    task automatic model_b();
        if (mode_i == 2'b01) begin
            if (equ == 4) eq0 = 1 - eq0;
            equ = (equ + 1) % 5;
        end else if (mode_i != 2'b00) begin
            equ = (equ + 1) % 5;
        end
    endtask

    task automatic model_ctl();
        if (nine_a_i && nine_b_i) begin eq0 = 1; equ = 4; end
        else if (clr_a_i && clr_b_i) begin eq0 = 0; equ = 0; end
    endtask

    // Rising half: the count must not move.
    task automatic pulse_a(input string tag);
        tick_a_i = 1'b1;
        repeat (4) @(negedge clk);
        check({tag, " rise"}, count_o, exp_val());
        tick_a_i = 1'b0;
        repeat (4) @(negedge clk);
        model_a();
        model_ctl();
        check(tag, count_o, exp_val());
    endtask

    task automatic pulse_b(input string tag);
        tick_b_i = 1'b1;
        repeat (4) @(negedge clk);
        tick_b_i = 1'b0;
        repeat (4) @(negedge clk);
        model_b();
        model_ctl();
        check(tag, count_o, exp_val());
    endtask

    task automatic do_clear();
        clr_a_i = 1'b1; clr_b_i = 1'b1;
        @(negedge clk);
        clr_a_i = 1'b0; clr_b_i = 1'b0;
        eq0 = 0; equ = 0;
        check("R2 clear", count_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset", count_o, 0);

        // BCD sweep over more than two full decades.
        mode_i = 2'b00;
        for (int i = 0; i < 25; i++) pulse_a("R5 bcd");
        pulse_b("R9 bcd ignores tick_b");
        pulse_b("R9 bcd ignores tick_b");

        // Latency of a strobe fall.
        tick_a_i = 1'b1;
        repeat (4) @(negedge clk);
        held = exp_val();
        tick_a_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R8 no change before third edge", count_o, held);
        @(negedge clk);
        model_a();
        check("R8 change on third edge", count_o, exp_val());

        // Mode change keeps the count.
        held = exp_val();
        mode_i = 2'b01;
        repeat (3) @(negedge clk);
        check("R10 mode write keeps count", count_o, held);

        // Bi-quinary sweep; the model gives bit 0 high for five counts.
        do_clear();
        for (int i = 0; i < 25; i++) begin
            pulse_b("R6 biq");
            check("R6 square bit0", count_o[0], ((i + 1) / 5) % 2);
        end
        pulse_a("R9 biq ignores tick_a");

        // Independent dividers.
        mode_i = 2'b10;
        repeat (2) @(negedge clk);
        check("R10 mode write keeps count", count_o, exp_val());
        for (int i = 0; i < 15; i++) begin
            if (i % 3 == 0) pulse_a("R7 indep a");
            else            pulse_b("R7 indep b");
        end

        // Spare code acts as independent.
        mode_i = 2'b11;
        for (int i = 0; i < 6; i++) begin
            if (i % 2 == 0) pulse_a("R10 spare a");
            else            pulse_b("R10 spare b");
        end

        // Sweep all sixteen control combinations in BCD mode.
        mode_i = 2'b00;
        for (int c = 0; c < 16; c++) begin
            pulse_a("R4 lead-in");
            clr_a_i  = c[0];
            clr_b_i  = c[1];
            nine_a_i = c[2];
            nine_b_i = c[3];
            repeat (2) @(negedge clk);
            model_ctl();
            if (c[2] && c[3])      check("R3 preset", count_o, 9);
            else if (c[0] && c[1]) check("R2 clear", count_o, 0);
            else                   check("R4 idle controls", count_o, exp_val());
            if (c[2] && c[3])      pulse_a("R3 preset holds");
            else if (c[0] && c[1]) pulse_a("R2 clear holds");
            else                   pulse_a("R4 counts");
            clr_a_i = 1'b0; clr_b_i = 1'b0; nine_a_i = 1'b0; nine_b_i = 1'b0;
            @(negedge clk);
        end

        // Preset then count wraps to zero in BCD.
        nine_a_i = 1'b1; nine_b_i = 1'b1;
        @(negedge clk);
        nine_a_i = 1'b0; nine_b_i = 1'b0;
        eq0 = 1; equ = 4;
        check("R3 preset nine", count_o, 9);
        pulse_a("R5 wrap 9 to 0");

        // Reset mid-run.
        pulse_a("R5 bcd");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        eq0 = 0; equ = 0;
        check("R1 reset mid-run", count_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule